// File: doc/BRIEF.md
# Dual-Bus Dual-Ported Register Bank

A bank of general-purpose registers placed between two shared internal data buses, called A and B. On every clock cycle each register may capture the value on either bus, put its contents onto either bus, or both at once. A controller supplies four one-hot-style enable vectors, with one bit per register: load from A, load from B, drive A, drive B. Each bus also has one external source port, so that a neighbouring unit such as an ALU or a memory data register can place a value on the bus.

The tristate buses are modelled as AND-OR multiplexers. The resolved bus values are combinational outputs, so the controller and the neighbouring units see in the same cycle whatever the registers drive. Register updates happen on the rising clock edge. The bank does not arbitrate or detect conflicting commands. Keeping two loads off one register and keeping each bus to a single driver is left to the controller. The behaviour under misuse is still defined, so that the results can be predicted.

Top module: `dual_bus_regbank`

## Requirements
- R1: An asserted `rst_ni` (low) clears every register to zero, and a register driven onto a bus afterwards reads as zero.
- R2: A bus with no register drive bit and no external source enable set reads as all zeros.
- R3: When register k is the only driver of a bus, that bus output equals register k's stored value in the same cycle, with no clock edge in between.
- R4: A single register may drive both buses in one cycle. Two different registers may drive A and B in the same cycle.
- R5: A set load-from-A (or load-from-B) bit for register k stores the value present on that bus at the next rising edge.
- R6: Two different registers may load in the same edge, one from each bus, including two registers exchanging their values through the two buses.
- R7: If both load bits of one register are set, the value from bus A is stored.
- R8: A register that drives a bus and loads in the same cycle drives its old value. The newly loaded value appears on the following cycle.
- R9: An enabled external source drives its bus, and registers can load that value.
- R10: When several drivers are enabled on one bus, the bus carries the bitwise OR of their values. No error is raised.
- R11: A register with neither load bit set keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_a_i | input | NUM_REGS | Per-register load from bus A |
| ld_b_i | input | NUM_REGS | Per-register load from bus B |
| drv_a_i | input | NUM_REGS | Per-register drive onto bus A |
| drv_b_i | input | NUM_REGS | Per-register drive onto bus B |
| src_a_en_i | input | 1 | External source drives bus A |
| src_a_i | input | WIDTH | External value for bus A |
| src_b_en_i | input | 1 | External source drives bus B |
| src_b_i | input | WIDTH | External value for bus B |
| bus_a_o | output | WIDTH | Resolved bus A value |
| bus_b_o | output | WIDTH | Resolved bus B value |

## Verification
The bound checker watches every cycle for the following: per-register load capture from the bus value of the previous cycle, A-over-B priority when both loads are set, holding when no load is set, zero on undriven buses, and a single driving register appearing on its bus. The bench scenarios are needed for the combined cases: reset contents seen through the buses, one register feeding both buses, swaps between two registers, drive-and-load in the same cycle with the new value showing one cycle later, and the OR result with several drivers. The bench compares every cycle's bus values against a reference model of the register contents.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DEF_NUM_REGS = 8;
  localparam int unsigned DEF_WIDTH    = 16;
endpackage

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int unsigned WIDTH = regbank_pkg::DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_a_i,
  input  logic             ld_b_i,
  input  logic [WIDTH-1:0] bus_a_i,
  input  logic [WIDTH-1:0] bus_b_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (ld_a_i) q_o <= bus_a_i;  // A wins on double load
    else if (ld_b_i) q_o <= bus_b_i;
  end
endmodule

// File: rtl/regbank_bus_mux.sv
module regbank_bus_mux #(
  parameter int unsigned NUM_SRC = regbank_pkg::DEF_NUM_REGS + 1,
  parameter int unsigned WIDTH   = regbank_pkg::DEF_WIDTH
) (
  input  logic [NUM_SRC-1:0]            sel_i,
  input  logic [NUM_SRC-1:0][WIDTH-1:0] data_i,
  output logic [WIDTH-1:0]              bus_o
);
  // AND-OR stand-in for a tristate bus: idle reads zero, contention ORs
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      bus_o |= data_i[i] & {WIDTH{sel_i[i]}};
  end
endmodule

// File: rtl/dual_bus_regbank.sv
module dual_bus_regbank #(
  parameter int unsigned NUM_REGS = regbank_pkg::DEF_NUM_REGS,
  parameter int unsigned WIDTH    = regbank_pkg::DEF_WIDTH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] ld_a_i,
  input  logic [NUM_REGS-1:0] ld_b_i,
  input  logic [NUM_REGS-1:0] drv_a_i,
  input  logic [NUM_REGS-1:0] drv_b_i,
  input  logic                src_a_en_i,
  input  logic [WIDTH-1:0]    src_a_i,
  input  logic                src_b_en_i,
  input  logic [WIDTH-1:0]    src_b_i,
  output logic [WIDTH-1:0]    bus_a_o,
  output logic [WIDTH-1:0]    bus_b_o
);
  localparam int unsigned NUM_SRC = NUM_REGS + 1;

  logic [NUM_REGS-1:0][WIDTH-1:0] reg_q;
  logic [NUM_SRC-1:0][WIDTH-1:0]  src_data_a, src_data_b;
  logic [NUM_SRC-1:0]             sel_a, sel_b;

  // slot NUM_REGS is the external source
  assign sel_a      = {src_a_en_i, drv_a_i};
  assign sel_b      = {src_b_en_i, drv_b_i};
  assign src_data_a = {src_a_i, reg_q};
  assign src_data_b = {src_b_i, reg_q};

  regbank_bus_mux #(.NUM_SRC(NUM_SRC), .WIDTH(WIDTH)) u_mux_a (
    .sel_i(sel_a), .data_i(src_data_a), .bus_o(bus_a_o)
  );
  regbank_bus_mux #(.NUM_SRC(NUM_SRC), .WIDTH(WIDTH)) u_mux_b (
    .sel_i(sel_b), .data_i(src_data_b), .bus_o(bus_b_o)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    regbank_cell #(.WIDTH(WIDTH)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_a_i (ld_a_i[k]),
      .ld_b_i (ld_b_i[k]),
      .bus_a_i(bus_a_o),
      .bus_b_i(bus_b_o),
      .q_o    (reg_q[k])
    );
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int unsigned NUM_REGS = regbank_pkg::DEF_NUM_REGS,
  parameter int unsigned WIDTH    = regbank_pkg::DEF_WIDTH
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_REGS-1:0]            ld_a_i,
  input logic [NUM_REGS-1:0]            ld_b_i,
  input logic [NUM_REGS-1:0]            drv_a_i,
  input logic [NUM_REGS-1:0]            drv_b_i,
  input logic                           src_a_en_i,
  input logic                           src_b_en_i,
  input logic [WIDTH-1:0]               bus_a_o,
  input logic [WIDTH-1:0]               bus_b_o,
  input logic [NUM_REGS-1:0][WIDTH-1:0] regs
);
  // R2
  idle_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_a_i == '0 && !src_a_en_i) |-> bus_a_o == '0);
  // R2
  idle_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_b_i == '0 && !src_b_en_i) |-> bus_b_o == '0);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    // R5 R7
    load_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_a_i[k] |=> regs[k] == $past(bus_a_o));
    // R5
    load_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_b_i[k] && !ld_a_i[k]) |=> regs[k] == $past(bus_b_o));
    // R11
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ld_a_i[k] && !ld_b_i[k]) |=> $stable(regs[k]));
    // R3
    drive_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_a_i == NUM_REGS'(1) << k && !src_a_en_i) |-> bus_a_o == regs[k]);
    // R3
    drive_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_b_i == NUM_REGS'(1) << k && !src_b_en_i) |-> bus_b_o == regs[k]);
  end
endmodule

bind dual_bus_regbank regbank_chk #(.NUM_REGS(NUM_REGS), .WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_a_i(ld_a_i), .ld_b_i(ld_b_i),
  .drv_a_i(drv_a_i), .drv_b_i(drv_b_i), .src_a_en_i(src_a_en_i),
  .src_b_en_i(src_b_en_i), .bus_a_o(bus_a_o), .bus_b_o(bus_b_o), .regs(reg_q)
);

// File: tb/sim_dual_bus_regbank.sv
`timescale 1ns/1ps
module sim_dual_bus_regbank;
  localparam int NR = 8;
  localparam int W  = 16;

  typedef struct {
    string      tag;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NR-1:0] ld_a = '0, ld_b = '0, drv_a = '0, drv_b = '0;
  logic sa_en = 1'b0, sb_en = 1'b0;
  logic [W-1:0] sa = '0, sb = '0;
  logic [W-1:0] bus_a, bus_b;

  logic [W-1:0] model [NR];
  exp_t exp_q [$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_bus_regbank #(.NUM_REGS(NR), .WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ld_a_i(ld_a), .ld_b_i(ld_b),
    .drv_a_i(drv_a), .drv_b_i(drv_b), .src_a_en_i(sa_en), .src_a_i(sa),
    .src_b_en_i(sb_en), .src_b_i(sb), .bus_a_o(bus_a), .bus_b_o(bus_b)
  );

  // one cycle of stimulus; expected buses from the model, then model update
  task automatic step(input string tag, input logic [NR-1:0] da, db, la, lb,
                      input logic sae, input logic [W-1:0] va,
                      input logic sbe, input logic [W-1:0] vb);
    exp_t e;
    @(negedge clk);
    drv_a = da; drv_b = db; ld_a = la; ld_b = lb;
    sa_en = sae; sa = va; sb_en = sbe; sb = vb;
    e.tag = tag;
    e.a = sae ? va : '0;
    e.b = sbe ? vb : '0;
    for (int i = 0; i < NR; i++) begin
      if (da[i]) e.a |= model[i];
      if (db[i]) e.b |= model[i];
    end
    exp_q.push_back(e);
    for (int i = 0; i < NR; i++) begin
      if (la[i])      model[i] = e.a;
      else if (lb[i]) model[i] = e.b;
    end
  endtask

  task automatic rd(input string tag, input int ra, input int rb);
    step(tag, NR'(1) << ra, NR'(1) << rb, '0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  // monitor: compares each cycle's buses against the pushed expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (bus_a !== e.a || bus_b !== e.b) begin
          n_fail++;
          $display("FAIL %s: bus_a=%h bus_b=%h expected a=%h b=%h",
                   e.tag, bus_a, bus_b, e.a, e.b);
        end
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset contents, R2 idle bus B
    for (int i = 0; i < NR; i++)
      step("R1", NR'(1) << i, '0, '0, '0, 1'b0, '0, 1'b0, '0);
    step("R2", '0, '0, '0, '0, 1'b0, '0, 1'b0, '0);

    // R9 R5 fill from external A source
    for (int i = 0; i < NR; i++)
      step("R9", '0, '0, NR'(1) << i, '0, 1'b1, W'(16'h1111 * (i + 1)), 1'b0, '0);
    // R5 load from B
    step("R5", '0, '0, '0, 8'h08, 1'b0, '0, 1'b1, 16'hBEEF);
    // R3 each register onto A alone
    for (int i = 0; i < NR; i++) rd("R3", i, (i + 1) % NR);
    // R4 different registers on each bus, then one on both
    rd("R4", 2, 5);
    rd("R4", 4, 4);
    // R6 two loads: r1 from external A, r6 from r3 driving B
    step("R6", '0, 8'h08, 8'h02, 8'h40, 1'b1, 16'hA5A5, 1'b0, '0);
    rd("R6", 1, 6);
    // R6 swap r4 and r5
    step("R6", 8'h10, 8'h20, 8'h20, 8'h10, 1'b0, '0, 1'b0, '0);
    rd("R6", 4, 5);
    // R7 double load on r0
    step("R7", '0, '0, 8'h01, 8'h01, 1'b1, 16'h1234, 1'b1, 16'h5678);
    rd("R7", 0, 0);
    // R8 r2 drives A and loads from B in one cycle
    step("R8", 8'h04, '0, '0, 8'h04, 1'b0, '0, 1'b1, 16'h0F0F);
    rd("R8", 2, 2);
    // R10 two drivers on A, register plus external on B
    step("R10", 8'h42, 8'h80, '0, '0, 1'b0, '0, 1'b1, 16'h00F0);
    // R11 idle cycles, loads off on the other bus, then read all
    step("R11", '0, '0, '0, '0, 1'b1, 16'hFFFF, 1'b1, 16'hFFFF);
    step("R11", '0, '0, '0, '0, 1'b0, '0, 1'b0, '0);
    for (int i = 0; i < NR; i++) rd("R11", i, NR - 1 - i);

    @(negedge clk);
    drv_a = '0; drv_b = '0; ld_a = '0; ld_b = '0; sa_en = 1'b0; sb_en = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule